// File: doc/BRIEF.md
# Clocked Multi-Channel Conversion Sequencer

This block produces the control timing for a run of back-to-back conversions over one to four channels. A single start pulse opens a sequence and raises `busy`. Each conversion lasts a fixed number of conversion-clock ticks. The conversion clock is modelled as a one-cycle enable `conv_en` inside the block's only clock domain.

Inside every conversion, one tick position (the 14th of 16 by default) is the only event that drives the result path:
- a one-cycle transfer strobe;
- a low pulse on the active-low end-of-conversion output, lasting one conversion tick;
- on the first conversion only, a read-pointer reset request and the setting of the first-data flag;
- on the second conversion only, the clearing of the first-data flag.

The current channel index steps after each conversion. After the last selected channel finishes, `busy` falls and the index returns to zero. The analog front end and the bit-decision logic sit outside this block and use the strobes it produces.

Top module: `conv_seq`

## Requirements
- R1: After reset, `busy`=0, `eoc_n`=1, `chan_idx`=0, `xfer_stb`=0, `ptr_rst`=0 and `first_data`=0.
- R2: A `start` sampled high while `busy` is 0 sets `busy` to 1 on that clock edge, and `chan_idx` reads 0.
- R3: Each conversion spans exactly 16 clock edges on which `conv_en` is high while busy. With `conv_en` held high, `busy` stays high for exactly 16×N clock cycles for N selected channels.
- R4: `xfer_stb` is high for exactly one clock cycle. This is the cycle after the edge that carries the 14th enabled tick of each conversion.
- R5: `eoc_n` goes low on the edge of the 14th tick of each conversion. It returns high on the next edge on which `conv_en` is high.
- R6: `ptr_rst` pulses together with `xfer_stb` on the first conversion (channel index 0) of a sequence, and at no other time.
- R7: `first_data` is set on the 14th tick of the first conversion and cleared on the 14th tick of the second conversion. At all other times it holds its value, including across the end of a sequence.
- R8: `chan_idx` increments on the 16th tick of each conversion that is not the last one. It is 0 whenever `busy` is 0.
- R9: A `start` pulse while `busy` is 1 has no effect on any output.
- R10: `chan_num` (3 bits, unsigned) selects the number of conversions. The value 0 means one conversion, and values above 4 mean four.
- R11: While busy, clock edges with `conv_en` low do not advance the conversion timing or the channel index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_en | input | 1 | One-cycle conversion-clock tick |
| start | input | 1 | Start-of-sequence request |
| chan_num | input | 3 | Number of channels to convert (0 means 1, above 4 means 4) |
| busy | output | 1 | High for the whole sequence |
| eoc_n | output | 1 | Active-low end-of-conversion pulse |
| chan_idx | output | 2 | Channel currently being converted |
| xfer_stb | output | 1 | One-cycle result-transfer strobe |
| ptr_rst | output | 1 | Read-pointer reset request on the first result |
| first_data | output | 1 | High while the first result is the newest |

## Verification
Directed sequences with `conv_en` held high, for channel counts 0, 1, 4 and 7, measure the length of `busy`. These runs separate correct per-conversion length and count clamping from off-by-one errors in the tick counter or the last-channel compare. A sequence that receives a second `start` in mid-run shows whether a re-trigger is ignored. Constrained-random runs, with sparse and dense `conv_en` and random starts and counts, compare every output each cycle against a bench model. These runs expose stalls during gaps in the enable, misplaced strobes, and first-data set or clear errors across consecutive sequences.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
   // clamp a requested channel count into the range 1..max_ch
   function automatic int unsigned clamp_count(input int unsigned req, input int unsigned max_ch);
      if (req == 0) return 1;
      if (req > max_ch) return max_ch;
      return req;
   endfunction
endpackage

// File: rtl/conv_tick_timer.sv
module conv_tick_timer #(
   parameter int CYC_PER_CONV = 16,
   parameter int XFER_CYC     = 14,
   localparam int CNT_W       = $clog2(CYC_PER_CONV)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic             conv_en,
   output logic             xfer_evt,
   output logic             end_evt,
   output logic [CNT_W-1:0] tick_q
);
   localparam logic [CNT_W-1:0] XFER_AT = CNT_W'(XFER_CYC - 1);
   localparam logic [CNT_W-1:0] LAST_AT = CNT_W'(CYC_PER_CONV - 1);

   assign xfer_evt = run && conv_en && (tick_q == XFER_AT);
   assign end_evt  = run && conv_en && (tick_q == LAST_AT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tick_q <= '0;
      else if (clr || end_evt)
         tick_q <= '0;
      else if (run && conv_en)
         tick_q <= tick_q + 1'b1;
   end

   // R11
   tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !conv_en && !clr) |=> $stable(tick_q));
endmodule

// File: rtl/conv_chan_track.sv
module conv_chan_track #(
   parameter int MAX_CH = 4,
   localparam int CH_W  = (MAX_CH > 1) ? $clog2(MAX_CH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_ok,
   input  logic [CH_W-1:0] last_ch,
   input  logic            end_evt,
   output logic            busy,
   output logic [CH_W-1:0] chan_idx
);
   logic [CH_W-1:0] last_q;
   logic            at_last;

   generate
      if (MAX_CH == 1) begin : g_single
         assign at_last  = 1'b1;
         assign chan_idx = '0;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) last_q <= '0;
            else        last_q <= '0;
      end else begin : g_multi
         logic [CH_W-1:0] idx_q;
         assign at_last  = (idx_q == last_q);
         assign chan_idx = idx_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               idx_q  <= '0;
               last_q <= '0;
            end else if (start_ok) begin
               idx_q  <= '0;
               last_q <= last_ch;
            end else if (end_evt) begin
               idx_q <= at_last ? '0 : idx_q + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                busy <= 1'b0;
      else if (start_ok)         busy <= 1'b1;
      else if (end_evt && at_last) busy <= 1'b0;
   end

   // R8
   idle_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (chan_idx == '0));
   // R9
   busy_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !end_evt) |=> (busy && $stable(chan_idx)));
endmodule

// File: rtl/conv_flag_unit.sv
module conv_flag_unit (
   input  logic clk,
   input  logic rst_n,
   input  logic conv_en,
   input  logic xfer_evt,
   input  logic on_first,
   input  logic on_second,
   output logic eoc_n,
   output logic xfer_stb,
   output logic ptr_rst,
   output logic first_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoc_n      <= 1'b1;
         xfer_stb   <= 1'b0;
         ptr_rst    <= 1'b0;
         first_data <= 1'b0;
      end else begin
         xfer_stb <= xfer_evt;
         ptr_rst  <= xfer_evt && on_first;
         if (xfer_evt)    eoc_n <= 1'b0;
         else if (conv_en) eoc_n <= 1'b1;
         if (xfer_evt && on_first)       first_data <= 1'b1;
         else if (xfer_evt && on_second) first_data <= 1'b0;
      end
   end

   // R4
   xfer_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_stb |=> !xfer_stb);
   // R5
   eoc_with_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eoc_n) |-> xfer_stb);
   // R6
   ptr_only_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_rst |-> xfer_stb);
   // R7
   first_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(first_data) |-> ptr_rst);
endmodule

// File: rtl/conv_seq.sv
module conv_seq #(
   parameter int CYC_PER_CONV = 16,
   parameter int XFER_CYC     = 14,
   parameter int MAX_CH       = 4,
   localparam int CH_W        = (MAX_CH > 1) ? $clog2(MAX_CH) : 1,
   localparam int NUM_W       = $clog2(MAX_CH + 1),
   localparam int CNT_W       = $clog2(CYC_PER_CONV)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_en,
   input  logic             start,
   input  logic [NUM_W-1:0] chan_num,
   output logic             busy,
   output logic             eoc_n,
   output logic [CH_W-1:0]  chan_idx,
   output logic             xfer_stb,
   output logic             ptr_rst,
   output logic             first_data
);
   import conv_seq_pkg::*;

   generate
      if (CYC_PER_CONV < 2) begin : g_bad_len
         $error("CYC_PER_CONV must be at least 2");
      end
      if (XFER_CYC < 1 || XFER_CYC >= CYC_PER_CONV) begin : g_bad_xfer
         $error("XFER_CYC must lie inside the conversion");
      end
      if (MAX_CH < 1) begin : g_bad_ch
         $error("MAX_CH must be at least 1");
      end
   endgenerate

   logic             start_ok, xfer_evt, end_evt;
   logic [CH_W-1:0]  last_ch;
   logic [CNT_W-1:0] tick_q;

   assign start_ok = start && !busy;
   assign last_ch  = CH_W'(clamp_count(int'(chan_num), MAX_CH) - 1);

   conv_tick_timer #(.CYC_PER_CONV(CYC_PER_CONV), .XFER_CYC(XFER_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(busy), .clr(start_ok), .conv_en(conv_en),
      .xfer_evt(xfer_evt), .end_evt(end_evt), .tick_q(tick_q));

   conv_chan_track #(.MAX_CH(MAX_CH)) u_chan (
      .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .last_ch(last_ch),
      .end_evt(end_evt), .busy(busy), .chan_idx(chan_idx));

   conv_flag_unit u_flag (
      .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .xfer_evt(xfer_evt),
      .on_first(chan_idx == CH_W'(0)),
      .on_second((MAX_CH > 1) && (chan_idx == CH_W'(1))),
      .eoc_n(eoc_n), .xfer_stb(xfer_stb), .ptr_rst(ptr_rst), .first_data(first_data));

   // R2
   start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> (busy && chan_idx == '0));
   // R3
   idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !xfer_stb);
endmodule

// File: tb/sim_conv_seq.sv
module sim_conv_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       conv_en = 1'b0;
   logic       start = 1'b0;
   logic [2:0] chan_num = 3'd0;
   logic       busy, eoc_n, xfer_stb, ptr_rst, first_data;
   logic [1:0] chan_idx;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   conv_seq u0 (
      .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .start(start), .chan_num(chan_num),
      .busy(busy), .eoc_n(eoc_n), .chan_idx(chan_idx), .xfer_stb(xfer_stb),
      .ptr_rst(ptr_rst), .first_data(first_data));

   // reference model, built from the requirements
   bit m_busy = 0, m_eoc_n = 1, m_xfer = 0, m_prst = 0, m_first = 0;
   int m_tick = 0, m_ch = 0, m_n = 1;

   function automatic int n_of(input logic [2:0] v);
      if (v == 0) return 1;
      if (v > 4) return 4;
      return int'(v);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; m_eoc_n = 1; m_xfer = 0; m_prst = 0; m_first = 0;
         m_tick = 0; m_ch = 0; m_n = 1;
      end else begin
         bit ev;
         ev = 0;
         m_xfer = 0; m_prst = 0;
         if (!m_busy) begin
            if (start) begin
               m_busy = 1; m_tick = 0; m_ch = 0; m_n = n_of(chan_num);
            end
         end else if (conv_en) begin
            m_tick++;
            if (m_tick == 14) begin
               ev = 1; m_xfer = 1;
               if (m_ch == 0) begin m_prst = 1; m_first = 1; end
               else if (m_ch == 1) m_first = 0;
            end
            if (m_tick == 16) begin
               m_tick = 0;
               if (m_ch == m_n - 1) begin m_busy = 0; m_ch = 0; end
               else m_ch++;
            end
         end
         if (ev) m_eoc_n = 0;
         else if (conv_en) m_eoc_n = 1;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cmp_all();
      check("R3 busy", busy, m_busy);
      check("R5 eoc_n", eoc_n, m_eoc_n);
      check("R8 chan_idx", chan_idx, m_ch);
      check("R4 xfer_stb", xfer_stb, m_xfer);
      check("R6 ptr_rst", ptr_rst, m_prst);
      check("R7 first_data", first_data, m_first);
   endtask

   // one clock step: drive at negedge, compare at next negedge
   task automatic step(input bit en, input bit st);
      conv_en = en; start = st;
      @(negedge clk);
      cmp_all();
   endtask

   // directed: conv_en held high, measure busy length
   task automatic run_len(input logic [2:0] num, input string req, input int exp_cyc, input int retrig_at);
      int cyc = 0, nx = 0, np = 0;
      chan_num = num;
      step(1, 1);
      while (busy && cyc < 200) begin
         cyc++;
         if (xfer_stb) nx++;
         if (ptr_rst) np++;
         step(1, (cyc == retrig_at) ? 1'b1 : 1'b0);
      end
      check({req, " busy length"}, cyc, exp_cyc);
      check("R4 strobe count", nx, exp_cyc / 16);
      check("R6 ptr reset count", np, 1);
      check("R8 idle index", chan_idx, 0);
   endtask

   initial begin
      #200000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7));
      repeat (2) @(negedge clk);
      // R1 reset state
      check("R1 busy", busy, 0);
      check("R1 eoc_n", eoc_n, 1);
      check("R1 chan_idx", chan_idx, 0);
      check("R1 xfer_stb", xfer_stb, 0);
      check("R1 ptr_rst", ptr_rst, 0);
      check("R1 first_data", first_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 start raises busy at once
      chan_num = 3'd2;
      step(0, 1);
      check("R2 busy after start", busy, 1);
      check("R2 index at start", chan_idx, 0);
      // R11 no ticks, nothing moves
      repeat (20) step(0, 0);
      check("R11 no xfer without ticks", xfer_stb, 0);
      check("R11 index held", chan_idx, 0);
      while (busy) step(1, 0);
      check("R7 first_data after two conversions", first_data, 0);
      // R3 / R10 lengths
      run_len(3'd1, "R3 one channel", 16, -1);
      check("R7 first_data kept after single", first_data, 1);
      run_len(3'd4, "R3 four channels", 64, -1);
      run_len(3'd0, "R10 zero count", 16, -1);
      run_len(3'd7, "R10 clamped count", 64, -1);
      // R9 start during busy ignored
      run_len(3'd3, "R9 retrigger", 48, 20);
      // random phase
      for (int i = 0; i < 6000; i++) begin
         bit en, st;
         if ((i / 500) % 2 == 0) en = ($urandom % 4) != 0;
         else en = ($urandom % 5) == 0;
         st = ($urandom % 40) == 0;
         chan_num = 3'($urandom % 8);
         step(en, st);
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule